// File: doc/BRIEF.md
# Multilane Receive Deskew Buffer

The block takes the decoded receive symbols of up to eight lanes and gathers them into one 64-bit word with one control flag per byte. Each lane brings an 8-bit symbol, a control flag and a valid strobe. Before storage, each symbol passes a per-lane filter:

- Ordered-set framing symbols (comma, skip and fast-training) are thrown away.
- Pad and idle control symbols become a plain zero data byte.

Each lane then stores its surviving symbols in its own small FIFO. A word is read out only when every lane marked active holds at least one symbol. Bytes of inactive lanes are zero.

The training state machine drives an enable input. While the enable is low, nothing is stored or read and all lane FIFOs are emptied. A sticky error flag records any symbol that arrived for a lane whose FIFO was full.

Top module: `rx_lane_aligner`

## Requirements
- R1: Each lane FIFO holds 8 symbols (FIFO_DEPTH). Eight writes with no read leave the error flag clear, and the symbols come out in arrival order.
- R2: A stored entry keeps 8 data bits and 1 control bit. Lane i appears on out_data[8i+7:8i] and on out_ctl[i].
- R3: A symbol with control flag 1 and value 0xBC (comma), 0x1C (skip) or 0x3C (fast training) is not stored.
- R4: A symbol with control flag 1 and value 0xF7 (pad) or 0x7C (idle) is stored as data 0x00 with control flag 0. Every other symbol is stored unchanged.
- R5: A read happens at a clock edge only when the enable is high, at least one lane is active, and every active lane FIFO holds at least one entry before that edge. The read word shows on the outputs with out_vld high for one cycle after that edge.
- R6: Inactive lanes (lane_active[i]=0) store nothing and do not block a read. Their bytes and control bits read as zero.
- R7: While align_en is 0, no symbol is stored and no read occurs. Every lane FIFO is emptied at that edge.
- R8: A write into a full lane FIFO with no read of that lane in the same cycle is dropped and sets ovf_err, which stays set until reset. A write and a read of the same full FIFO in the same cycle are both accepted.
- R9: After reset, out_vld, out_data, out_ctl and ovf_err are all 0. When out_vld is 0, out_data and out_ctl are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| align_en | input | 1 | Deskew enable from the training state machine |
| lane_active | input | 8 | Per-lane initialised mask |
| lane_vld | input | 8 | Per-lane symbol valid |
| lane_sym | input | 64 | Per-lane symbol bytes, lane i at [8i+7:8i] |
| lane_ctl | input | 8 | Per-lane symbol control flag |
| out_data | output | 64 | Aligned data word |
| out_ctl | output | 8 | Per-byte control flags of the word |
| out_vld | output | 1 | Aligned word valid |
| ovf_err | output | 1 | Sticky lane FIFO overflow error |

## Verification
A read of a full lane and a new symbol for that same lane can land in one cycle. This decides whether the symbol is kept or counted as an overflow. The bench fills one lane to eight entries while a second active lane stays empty. It then feeds the second lane a single symbol, so the next cycle brings a read and a write to the full lane together. The output word and a clear error flag are compared with a bench model, and a later write with the partner lane empty again is expected to raise the flag.

// File: rtl/rxal_pkg.sv
package rxal_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic              k;
        logic [BYTE_W-1:0] d;
    } sym_t;

    localparam logic [BYTE_W-1:0] K_COMMA = 8'hBC;
    localparam logic [BYTE_W-1:0] K_SKIP  = 8'h1C;
    localparam logic [BYTE_W-1:0] K_FTRN  = 8'h3C;
    localparam logic [BYTE_W-1:0] K_PAD   = 8'hF7;
    localparam logic [BYTE_W-1:0] K_IDLE  = 8'h7C;

endpackage

// File: rtl/rxal_sym_filter.sv
module rxal_sym_filter
    import rxal_pkg::*;
(
    input  logic in_vld,
    input  sym_t in_sym,
    output logic keep,
    output sym_t out_sym
);

    logic is_drop;
    logic is_fill;

    always_comb begin
        is_drop = in_sym.k && (in_sym.d == K_COMMA || in_sym.d == K_SKIP ||
                               in_sym.d == K_FTRN);
        is_fill = in_sym.k && (in_sym.d == K_PAD || in_sym.d == K_IDLE);
        keep    = in_vld && !is_drop;
        out_sym = is_fill ? '0 : in_sym;
    end

endmodule

// File: rtl/rxal_lane_fifo.sv
module rxal_lane_fifo
    import rxal_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic wr_en,
    input  sym_t wr_sym,
    input  logic rd_en,
    output sym_t head,
    output logic empty,
    output logic full,
    output logic ovf
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        sym_t [DEPTH-1:0] mem;
        logic [PW-1:0]    rd_ptr;
        logic [PW-1:0]    wr_ptr;
        logic [CW-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_rd, do_wr, ovf_d;

    always_comb begin
        st_d  = st_q;
        do_rd = 1'b0;
        do_wr = 1'b0;
        ovf_d = 1'b0;
        if (flush) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            do_rd = rd_en && (st_q.cnt != '0);
            do_wr = wr_en && ((st_q.cnt != CW'(DEPTH)) || do_rd);
            ovf_d = wr_en && (st_q.cnt == CW'(DEPTH)) && !do_rd;
            if (do_wr) begin
                st_d.mem[st_q.wr_ptr] = wr_sym;
                st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
            end
            if (do_rd) begin
                st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd_ptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign ovf   = ovf_d;

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> full);

endmodule

// File: rtl/rx_lane_aligner.sv
module rx_lane_aligner
    import rxal_pkg::*;
#(
    parameter int unsigned NUM_LANES  = 8,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        align_en,
    input  logic [NUM_LANES-1:0]        lane_active,
    input  logic [NUM_LANES-1:0]        lane_vld,
    input  logic [NUM_LANES*BYTE_W-1:0] lane_sym,
    input  logic [NUM_LANES-1:0]        lane_ctl,
    output logic [NUM_LANES*BYTE_W-1:0] out_data,
    output logic [NUM_LANES-1:0]        out_ctl,
    output logic                        out_vld,
    output logic                        ovf_err
);

    typedef struct packed {
        logic [NUM_LANES-1:0][BYTE_W-1:0] data;
        logic [NUM_LANES-1:0]             ctl;
        logic                             vld;
        logic                             ovf;
    } top_st_t;

    top_st_t st_d, st_q;

    sym_t [NUM_LANES-1:0] heads;
    logic [NUM_LANES-1:0] empty, full, ovf_p, keep, wr_en, rd_en;
    logic                 rd_go;

    assign rd_go = align_en && (|lane_active) && (&(~lane_active | ~empty));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        sym_t raw_sym, clean_sym;
        assign raw_sym = '{k: lane_ctl[i], d: lane_sym[BYTE_W*i +: BYTE_W]};

        rxal_sym_filter u_filt (
            .in_vld  (lane_vld[i]),
            .in_sym  (raw_sym),
            .keep    (keep[i]),
            .out_sym (clean_sym)
        );

        assign wr_en[i] = align_en && lane_active[i] && keep[i];
        assign rd_en[i] = rd_go && lane_active[i];

        rxal_lane_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (!align_en),
            .wr_en  (wr_en[i]),
            .wr_sym (clean_sym),
            .rd_en  (rd_en[i]),
            .head   (heads[i]),
            .empty  (empty[i]),
            .full   (full[i]),
            .ovf    (ovf_p[i])
        );
    end

    always_comb begin
        st_d     = '0;
        st_d.vld = rd_go;
        st_d.ovf = st_q.ovf | (|ovf_p);
        for (int i = 0; i < NUM_LANES; i++) begin
            if (rd_en[i]) begin
                st_d.data[i] = heads[i].d;
                st_d.ctl[i]  = heads[i].k;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data = st_q.data;
    assign out_ctl  = st_q.ctl;
    assign out_vld  = st_q.vld;
    assign ovf_err  = st_q.ovf;

    // R7
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |=> !out_vld);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R9
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_data == '0 && out_ctl == '0));

    // R5
    vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(align_en));

endmodule

// File: tb/tb_rx_lane_aligner.sv
module tb_rx_lane_aligner;

    localparam int NL = 8;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          align_en = 1'b0;
    logic [NL-1:0] lane_active = '0;
    logic [NL-1:0] lane_vld = '0;
    logic [NL*8-1:0] lane_sym = '0;
    logic [NL-1:0] lane_ctl = '0;
    logic [NL*8-1:0] out_data;
    logic [NL-1:0] out_ctl;
    logic          out_vld;
    logic          ovf_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [8:0] mbuf [NL][DP];
    int         mcnt [NL];
    logic       movf = 1'b0;

    always #4 clk = ~clk;

    rx_lane_aligner #(.NUM_LANES(NL), .FIFO_DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .align_en(align_en),
        .lane_active(lane_active), .lane_vld(lane_vld),
        .lane_sym(lane_sym), .lane_ctl(lane_ctl),
        .out_data(out_data), .out_ctl(out_ctl),
        .out_vld(out_vld), .ovf_err(ovf_err)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish");
                summary();
            end
        end
    end

    // returns {keep, k, d}
    function automatic logic [9:0] fmap(input logic k, input logic [7:0] d);
        if (k && (d == 8'hBC || d == 8'h1C || d == 8'h3C)) return {1'b0, k, d};
        if (k && (d == 8'hF7 || d == 8'h7C)) return {1'b1, 9'h000};
        return {1'b1, k, d};
    endfunction

    task automatic step(input logic en, input logic [NL-1:0] act,
                        input logic [NL-1:0] vld, input logic [NL*8-1:0] syms,
                        input logic [NL-1:0] ctls, input string tag);
        logic          rd;
        logic [NL*8-1:0] ed;
        logic [NL-1:0] ec;
        logic [9:0]    f;
        align_en = en; lane_active = act; lane_vld = vld;
        lane_sym = syms; lane_ctl = ctls;
        rd = en && (act != '0);
        for (int i = 0; i < NL; i++) if (act[i] && mcnt[i] == 0) rd = 1'b0;
        ed = '0; ec = '0;
        for (int i = 0; i < NL; i++) begin
            if (rd && act[i]) begin
                ed[8*i +: 8] = mbuf[i][0][7:0];
                ec[i] = mbuf[i][0][8];
            end
        end
        for (int i = 0; i < NL; i++) begin
            if (!en) begin
                mcnt[i] = 0;
            end else begin
                if (rd && act[i]) begin
                    for (int j = 0; j < DP - 1; j++) mbuf[i][j] = mbuf[i][j+1];
                    mcnt[i]--;
                end
                f = fmap(ctls[i], syms[8*i +: 8]);
                if (act[i] && vld[i] && f[9]) begin
                    if (mcnt[i] < DP) begin
                        mbuf[i][mcnt[i]] = f[8:0];
                        mcnt[i]++;
                    end else begin
                        movf = 1'b1;
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_vld !== rd || out_data !== ed || out_ctl !== ec) begin
            errors++;
            $display("FAIL %s: vld/data/ctl actual %b/%h/%h expected %b/%h/%h",
                     tag, out_vld, out_data, out_ctl, rd, ed, ec);
        end
        checks++;
        if (ovf_err !== movf) begin
            errors++;
            $display("FAIL %s (R8 flag): ovf_err actual %b expected %b", tag, ovf_err, movf);
        end
    endtask

    function automatic logic [NL*8-1:0] fill8(input logic [7:0] b);
        return {NL{b}};
    endfunction

    initial begin
        logic [NL*8-1:0] s;
        logic [NL-1:0]   c, v, a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) mcnt[i] = 0;
        #20;
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || out_data !== '0 || out_ctl !== '0 || ovf_err !== 1'b0) begin
            errors++;
            $display("FAIL R9: reset outputs actual %b/%h/%h/%b expected 0/0/0/0",
                     out_vld, out_data, out_ctl, ovf_err);
        end
        rst_n = 1'b1;
        step(1'b0, '1, '1, fill8(8'h11), '0, "R9");
        step(1'b1, '1, '0, '0, '0, "R9");

        // R3: ordered-set symbols dropped
        step(1'b1, '1, '1, fill8(8'hBC), '1, "R3");
        step(1'b1, '1, '1, {4{8'h1C, 8'h3C}}, '1, "R3");
        step(1'b1, '1, '0, '0, '0, "R3");
        // R4: pad / idle become zero data
        step(1'b1, '1, '1, {4{8'hF7, 8'h7C}}, '1, "R4");
        step(1'b1, '1, '0, '0, '0, "R4");
        // R2: data and control kept, other K symbol passes
        step(1'b1, '1, '1, 64'h0123_4567_89AB_CDEF, 8'h00, "R2");
        step(1'b1, '1, '1, fill8(8'hFB), 8'hA5, "R2");
        step(1'b1, '1, '0, '0, '0, "R2");

        // R6: inactive lanes ignored and zero
        step(1'b1, 8'b0000_0101, '1, 64'hFFEE_DDCC_BBAA_9988, '0, "R6");
        step(1'b1, 8'b0000_0101, 8'b0000_0001, fill8(8'h42), '0, "R6");
        step(1'b1, 8'b0000_0101, 8'b0000_0100, fill8(8'h24), '0, "R6");
        step(1'b1, 8'b0000_0101, '0, '0, '0, "R6");

        // R7: partial data flushed by disable
        step(1'b1, '1, 8'b0000_0001, fill8(8'h55), '0, "R7");
        step(1'b1, '1, 8'b0000_0011, fill8(8'h66), '0, "R7");
        step(1'b0, '1, '1, fill8(8'h77), '0, "R7");
        step(1'b1, '1, '1, fill8(8'h88), '0, "R7");
        step(1'b1, '1, '0, '0, '0, "R7");

        // R1: eight entries fit in lane 0 while lane 1 is empty
        for (int n = 0; n < DP; n++)
            step(1'b1, 8'b11, 8'b01, fill8(8'(8'h30 + n)), '0, "R1");
        // R8: read and write of the full lane in one cycle
        step(1'b1, 8'b11, 8'b10, fill8(8'hA0), '0, "R8");
        step(1'b1, 8'b11, 8'b01, fill8(8'hA1), '0, "R8");
        // R8: write into the full lane with no read
        step(1'b1, 8'b11, 8'b01, fill8(8'hA2), '0, "R8");
        for (int n = 0; n < DP + 1; n++)
            step(1'b1, 8'b11, 8'b10, fill8(8'hB0), '0, "R1");

        // R5: random traffic
        a = '1;
        for (int n = 0; n < 3000; n++) begin
            if (n % 200 == 0) begin
                a = NL'($urandom);
                if (a == '0) a = 8'h81;
                if (n % 400 == 0) a = '1;
            end
            for (int i = 0; i < NL; i++) begin
                v[i] = ($urandom % 10) < 8;
                if (($urandom % 4) == 0) begin
                    c[i] = 1'b1;
                    case ($urandom % 6)
                        0: s[8*i +: 8] = 8'hBC;
                        1: s[8*i +: 8] = 8'h1C;
                        2: s[8*i +: 8] = 8'h3C;
                        3: s[8*i +: 8] = 8'hF7;
                        4: s[8*i +: 8] = 8'h7C;
                        default: s[8*i +: 8] = 8'hFB;
                    endcase
                end else begin
                    c[i] = 1'b0;
                    s[8*i +: 8] = 8'($urandom);
                end
            end
            step(($urandom % 50) != 0, a, v, s, c, "R5");
        end
        summary();
    end

endmodule